// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block takes an Ethernet PHY from power-on to a running link negotiation without software help. One pulse on `start` turns on the management port enable and runs a fixed series of steps. A soft-reset write goes to the PHY control register. A quiet period follows in which the management bus is left idle. A second write to the same control register enables auto-negotiation and restarts it. Finally the link-status bit of the PHY status register is polled until link comes up or a time budget runs out.

The block holds its own management frame engine. That engine divides the system clock down to MDC, shifts out the 32-bit preamble and the frame fields, and releases the data line for read turnaround. The management data line is split into output, output-enable and input so the pad can sit outside the block. Wait lengths and the link budget are parameters in system clock cycles, so the same RTL serves silicon timing (50 ms and about 1 s at 50 MHz) and short simulation runs.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, busy, done, link_up, timeout, mgmt_en, mdc and mdio_oe are all 0, and mdio_o is 1.
- R2: An accepted start raises mgmt_en, which stays high until reset. mgmt_en is already high at every MDC rising edge.
- R3: Every management frame is MSB first: 32 ones, start bits 0 then 1, a 2-bit opcode, the 5-bit parameter PHY_ADDR, then a 5-bit register address.
- R4: MDC is low when idle and each MDC phase lasts CLK_DIV system cycles (the default of 10 gives 2.5 MHz from 50 MHz). The block changes mdio_o and mdio_oe only when MDC falls, so both are stable while MDC is high.
- R5: The first frame is a write (opcode 01) to register 0 with turnaround bits 1,0 and data 0x8000 (bit 15, soft reset).
- R6: After the reset write, no MDC edge occurs for at least RESET_WAIT system cycles.
- R7: The second frame is a write to register 0 with data 0x1200: bit 12 enables auto-negotiation and bit 9 restarts it.
- R8: All later frames are reads (opcode 10) of register 1. mdio_oe is low from the first turnaround bit to the end of the frame, and the 16 data bits are sampled on MDC rising edges.
- R9: A read with bit 2 set ends the run with done=1 and link_up=1. A read without bit 2 that finishes once at least LINK_LIMIT cycles have passed since the second write ends the run with done=1 and timeout=1. When both apply to the same read, link_up wins and timeout stays 0.
- R10: busy is high from the cycle after an accepted start until done rises. A start while busy is ignored, and a start after done clears done, link_up and timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin the bring-up sequence |
| mgmt_en | output | 1 | Management port enable, high before any traffic |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (held until next start) |
| link_up | output | 1 | Link seen in status register |
| timeout | output | 1 | Link budget expired without link |

## Verification
Two things can happen on the same cycle: a poll read that returns link and the expiry of the link budget. The decision is made when a read completes, so the bench's responder withholds the link bit until the third status read. The budget is set so that it runs out between the second and third reads. The run must then end with link_up high and timeout low, and a separate run that never reports link must end with timeout after exactly three reads.

// File: rtl/phyb_pkg.sv
// Package: shared constants and state type for the PHY bring-up sequencer.
// Assumes clause-22 style management frames of 64 bits including preamble.
package phyb_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;   // first turnaround bit index
    localparam int DATA_POS   = 48;   // first data bit index
    localparam logic [1:0]  OP_WR = 2'b01;
    localparam logic [1:0]  OP_RD = 2'b10;
    localparam logic [4:0]  REG_CTRL = 5'd0;
    localparam logic [4:0]  REG_STAT = 5'd1;
    localparam logic [15:0] CTRL_SOFT_RST = 16'h8000;
    localparam logic [15:0] CTRL_AN_GO    = 16'h1200;
    localparam logic [15:0] STAT_LINK_MASK = 16'h0004;

    typedef enum logic [2:0] {
        S_IDLE, S_ENABLE, S_WR_RST, S_QUIET, S_WR_AN, S_POLL, S_GAP
    } seq_state_t;
endpackage

// File: rtl/mdc_tick_gen.sv
// Module: mdc_tick_gen
// Emits a one-cycle tick every DIV system cycles while run is high; the
// count restarts from zero whenever run is low. Assumes DIV >= 2.
module mdc_tick_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system cycles within one MDC half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_frame_engine.sv
// Module: mdio_frame_engine
// Sends one management frame per request: preamble, start, opcode, PHY and
// register address, turnaround and 16 data bits, MSB first. Data changes on
// the falling MDC edge; read data is sampled on the rising edge. Assumes req
// is only pulsed while the engine is idle (done has been seen).
module mdio_frame_engine
    import phyb_pkg::*;
#(
    parameter int          DIV      = 10,
    parameter logic [4:0]  PHY_ADDR = 5'd1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        is_read,
    input  logic [4:0]  reg_addr,
    input  logic [15:0] wdata,
    input  logic        mdio_i,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0] TA_BIT   = BW'(TA_POS);
    localparam logic [BW-1:0] DATA_BIT = BW'(DATA_POS);

    logic                  active;
    logic                  rd_q;
    logic [BW-1:0]         bit_cnt;
    logic [FRAME_BITS-1:0] frame_q;
    logic [FRAME_BITS-1:0] frame_new;
    logic                  tick;
    logic [BW-1:0]         next_bit;

    mdc_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (active),
        .tick (tick)
    );

    // Assemble the frame image for a new request.
    always_comb begin
        frame_new = {32'hFFFF_FFFF, 2'b01, (is_read ? OP_RD : OP_WR),
                     PHY_ADDR, reg_addr, (is_read ? 2'b11 : 2'b10),
                     (is_read ? 16'hFFFF : wdata)};
        next_bit  = bit_cnt + 1'b1;
    end

    // Frame shifter, MDC phase and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            rd_q    <= 1'b0;
            bit_cnt <= '0;
            frame_q <= '1;
            mdc     <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (req) begin
                    frame_q <= frame_new;
                    active  <= 1'b1;
                    rd_q    <= is_read;
                    bit_cnt <= '0;
                    mdc     <= 1'b0;
                    mdio_oe <= 1'b1;
                end
            end else if (tick) begin
                if (!mdc) begin
                    mdc <= 1'b1;
                    if (rd_q && bit_cnt >= DATA_BIT) begin
                        rdata <= {rdata[14:0], mdio_i};
                    end
                end else begin
                    mdc <= 1'b0;
                    if (bit_cnt == LAST_BIT) begin
                        active  <= 1'b0;
                        done    <= 1'b1;
                        mdio_oe <= 1'b0;
                        frame_q <= '1;
                    end else begin
                        bit_cnt <= next_bit;
                        frame_q <= {frame_q[FRAME_BITS-2:0], 1'b1};
                        mdio_oe <= !(rd_q && next_bit >= TA_BIT);
                    end
                end
            end
        end
    end

    assign mdio_o = frame_q[FRAME_BITS-1];

    // R4: data and enable hold steady through the MDC high phase
    p_mdio_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8: line is released for the whole turnaround and data phase of a read
    p_read_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_q && bit_cnt >= TA_BIT) |-> !mdio_oe);

    // R4: MDC only toggles while a frame is active
    p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !mdc);
endmodule

// File: rtl/phy_bringup_seq.sv
// Module: phy_bringup_seq
// Top: enables the management port, soft-resets the PHY, waits RESET_WAIT
// cycles with the bus idle, starts auto-negotiation and polls link status
// until link or until LINK_LIMIT cycles have passed. Assumes mdio_i is
// pulled high by the pad when nobody drives it.
module phy_bringup_seq
    import phyb_pkg::*;
#(
    parameter int         CLK_DIV    = 10,
    parameter logic [4:0] PHY_ADDR   = 5'd1,
    parameter int         RESET_WAIT = 2_500_000,
    parameter int         LINK_LIMIT = 50_000_000,
    parameter int         POLL_GAP   = 5_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic mgmt_en,
    output logic mdc,
    output logic mdio_o,
    output logic mdio_oe,
    input  logic mdio_i,
    output logic busy,
    output logic done,
    output logic link_up,
    output logic timeout
);
    localparam int WMAX = (RESET_WAIT > POLL_GAP) ? RESET_WAIT : POLL_GAP;
    localparam int WCW  = $clog2(WMAX + 1);
    localparam int ECW  = $clog2(LINK_LIMIT + 1);
    localparam logic [WCW-1:0] QUIET_END = WCW'(RESET_WAIT - 1);
    localparam logic [WCW-1:0] GAP_END   = WCW'(POLL_GAP - 1);
    localparam logic [ECW-1:0] BUDGET    = ECW'(LINK_LIMIT);

    seq_state_t     state;
    logic [WCW-1:0] wcnt;
    logic [ECW-1:0] elapsed;
    logic           eng_req;
    logic           eng_rd;
    logic [4:0]     eng_reg;
    logic [15:0]    eng_wdata;
    logic           eng_done;
    logic [15:0]    eng_rdata;
    logic           link_seen;

    mdio_frame_engine #(.DIV(CLK_DIV), .PHY_ADDR(PHY_ADDR)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (eng_req),
        .is_read (eng_rd),
        .reg_addr(eng_reg),
        .wdata   (eng_wdata),
        .mdio_i  (mdio_i),
        .done    (eng_done),
        .rdata   (eng_rdata),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    assign link_seen = (eng_rdata & STAT_LINK_MASK) != '0;

    // Sequence control, timers and registered status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            wcnt      <= '0;
            elapsed   <= '0;
            eng_req   <= 1'b0;
            eng_rd    <= 1'b0;
            eng_reg   <= '0;
            eng_wdata <= '0;
            mgmt_en   <= 1'b0;
            busy      <= 1'b0;
            done      <= 1'b0;
            link_up   <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            eng_req <= 1'b0;
            if (state == S_POLL || state == S_GAP) begin
                if (elapsed != '1) elapsed <= elapsed + 1'b1;
            end
            case (state)
                S_IDLE: if (start) begin
                    state   <= S_ENABLE;
                    mgmt_en <= 1'b1;
                    busy    <= 1'b1;
                    done    <= 1'b0;
                    link_up <= 1'b0;
                    timeout <= 1'b0;
                end
                S_ENABLE: begin
                    state     <= S_WR_RST;
                    eng_req   <= 1'b1;
                    eng_rd    <= 1'b0;
                    eng_reg   <= REG_CTRL;
                    eng_wdata <= CTRL_SOFT_RST;
                end
                S_WR_RST: if (eng_done) begin
                    state <= S_QUIET;
                    wcnt  <= '0;
                end
                S_QUIET: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == QUIET_END) begin
                        state     <= S_WR_AN;
                        eng_req   <= 1'b1;
                        eng_rd    <= 1'b0;
                        eng_reg   <= REG_CTRL;
                        eng_wdata <= CTRL_AN_GO;
                    end
                end
                S_WR_AN: if (eng_done) begin
                    state   <= S_POLL;
                    elapsed <= '0;
                    eng_req <= 1'b1;
                    eng_rd  <= 1'b1;
                    eng_reg <= REG_STAT;
                end
                S_POLL: if (eng_done) begin
                    if (link_seen) begin
                        state   <= S_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        link_up <= 1'b1;
                    end else if (elapsed >= BUDGET) begin
                        state   <= S_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        timeout <= 1'b1;
                    end else begin
                        state <= S_GAP;
                        wcnt  <= '0;
                    end
                end
                S_GAP: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == GAP_END) begin
                        state   <= S_POLL;
                        eng_req <= 1'b1;
                        eng_rd  <= 1'b1;
                        eng_reg <= REG_STAT;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R6: bus stays silent through the post-reset wait
    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_QUIET) |-> (!mdc && !mdio_oe));

    // R2: no MDC activity without the management enable
    p_enable_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> mgmt_en);

    // R9: the two outcomes never appear together
    p_outcome_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up && timeout));

    // R10: busy and done are never high together
    p_busy_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
    localparam int         DIV    = 2;
    localparam logic [4:0] PHY    = 5'd3;
    localparam int         RWAIT  = 300;
    localparam int         LLIM   = 700;
    localparam int         GAP    = 20;
    localparam int         WD_MAX = 100_000;

    typedef struct {
        bit         rd;
        bit [4:0]   ra;
        bit [15:0]  d;
    } frm_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mgmt_en, mdc, mdio_o, mdio_oe, mdio_i;
    logic busy, done, link_up, timeout;
    logic slv_oe = 1'b0;
    logic slv_d = 1'b1;
    logic mdio_line;

    int n_chk = 0;
    int n_fail = 0;
    int link_on_read = 0;
    int rd_count = 0;
    int cyc = 0;
    bit phase_bad = 1'b0;
    bit stab_bad = 1'b0;
    bit coll_bad = 1'b0;
    bit en_bad = 1'b0;
    frm_t expq[$];

    always #10 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (slv_oe ? slv_d : 1'b1);
    assign mdio_i = mdio_line;

    phy_bringup_seq #(
        .CLK_DIV(DIV), .PHY_ADDR(PHY), .RESET_WAIT(RWAIT),
        .LINK_LIMIT(LLIM), .POLL_GAP(GAP)
    ) i_phy_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mgmt_en(mgmt_en),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .busy(busy), .done(done), .link_up(link_up), .timeout(timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_MAX) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Line monitor: MDC phase length, data stability, bus collisions (R4, R8, R2).
    logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
    int   ph_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc != prev_mdc) begin
                if (prev_mdc && ph_cnt != DIV) phase_bad = 1'b1;
                if (!prev_mdc && ph_cnt < DIV) phase_bad = 1'b1;
                if (mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) stab_bad = 1'b1;
                ph_cnt = 1;
            end else begin
                ph_cnt++;
                if (mdc && (mdio_o != prev_o || mdio_oe != prev_oe)) stab_bad = 1'b1;
            end
            if (mdio_oe && slv_oe) coll_bad = 1'b1;
            if (mdc && !mgmt_en) en_bad = 1'b1;
        end
        prev_mdc = mdc;
        prev_o = mdio_o;
        prev_oe = mdio_oe;
    end

    task automatic rd_bit(output bit b);
        @(posedge mdc);
        b = mdio_line;
    endtask

    // Monitor / PHY responder: decodes each frame and pops the scoreboard.
    initial begin : slave
        bit b;
        int ones;
        bit [1:0] op;
        bit [4:0] pa, ra;
        bit [1:0] ta;
        bit [15:0] dat, val;
        realtime t_first, t_last;
        realtime t_rst_end;
        bit after_rst;
        frm_t e;
        after_rst = 1'b0;
        t_rst_end = 0;
        forever begin
            rd_bit(b);
            t_first = $realtime;
            if (after_rst) begin
                check(((t_first - t_rst_end) / 20.0) >= RWAIT, "R6 quiet cycles",
                      int'((t_first - t_rst_end) / 20.0), RWAIT);
                after_rst = 1'b0;
            end
            ones = 0;
            while (b) begin
                ones++;
                rd_bit(b);
            end
            check(ones == 32, "R3 preamble", ones, 32);
            rd_bit(b);
            check(b == 1'b1, "R3 start bits", b, 1);
            op = '0; pa = '0; ra = '0; ta = '0; dat = '0;
            for (int i = 0; i < 2; i++) begin rd_bit(b); op = {op[0], b}; end
            for (int i = 0; i < 5; i++) begin rd_bit(b); pa = {pa[3:0], b}; end
            for (int i = 0; i < 5; i++) begin rd_bit(b); ra = {ra[3:0], b}; end
            check(pa == PHY, "R3 phy address", pa, PHY);
            if (op == 2'b10) begin
                rd_count++;
                val = (link_on_read != 0 && rd_count >= link_on_read) ? 16'h7809 | 16'h0004 : 16'h7809;
                @(negedge mdc);
                rd_bit(b);
                @(negedge mdc);
                slv_oe = 1'b1;
                slv_d = 1'b0;
                rd_bit(b);
                for (int i = 15; i >= 0; i--) begin
                    @(negedge mdc);
                    slv_d = val[i];
                    rd_bit(b);
                end
                @(negedge mdc);
                slv_oe = 1'b0;
                slv_d = 1'b1;
            end else begin
                for (int i = 0; i < 2; i++) begin rd_bit(b); ta = {ta[0], b}; end
                for (int i = 0; i < 16; i++) begin rd_bit(b); dat = {dat[14:0], b}; end
                check(ta == 2'b10, "R5 write turnaround", ta, 2);
            end
            t_last = $realtime;
            if (expq.size() == 0) begin
                check(1'b0, "R8 unexpected frame", {op, ra}, 0);
            end else begin
                e = expq.pop_front();
                check(op == (e.rd ? 2'b10 : 2'b01), e.rd ? "R8 read opcode" : "R5 R7 write opcode",
                      op, e.rd ? 2 : 1);
                check(ra == e.ra, e.rd ? "R8 status register" : "R5 R7 control register", ra, e.ra);
                if (!e.rd) begin
                    check(dat == e.d, (e.d == 16'h8000) ? "R5 reset data" : "R7 autoneg data", dat, e.d);
                    if (e.d == 16'h8000) begin
                        after_rst = 1'b1;
                        t_rst_end = t_last;
                    end
                end
            end
        end
    end

    // Driver: queues the expected frames and runs one bring-up.
    task automatic run_case(input int link_n, input int nreads, input bit exp_link,
                            input bit poke, input string tag);
        frm_t f;
        link_on_read = link_n;
        rd_count = 0;
        phase_bad = 0; stab_bad = 0; coll_bad = 0; en_bad = 0;
        f.rd = 0; f.ra = 5'd0; f.d = 16'h8000; expq.push_back(f);
        f.rd = 0; f.ra = 5'd0; f.d = 16'h1200; expq.push_back(f);
        for (int i = 0; i < nreads; i++) begin
            f.rd = 1; f.ra = 5'd1; f.d = 16'h0; expq.push_back(f);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R10 busy after start", busy, 1);
        check(done == 0 && link_up == 0 && timeout == 0, "R10 status cleared",
              {done, link_up, timeout}, 0);
        check(mgmt_en == 1'b1, "R2 enable raised", mgmt_en, 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            @(negedge clk);
            check(busy == 1'b1, "R10 start while busy", busy, 1);
        end
        while (!done) begin
            @(negedge clk);
            if (!done && !busy) begin
                check(1'b0, "R10 busy dropped early", busy, 1);
                break;
            end
        end
        repeat (3) @(negedge clk);
        check(link_up == exp_link && timeout == !exp_link,
              {"R9 outcome ", tag}, {link_up, timeout}, {exp_link, !exp_link});
        check(busy == 0 && done == 1, "R10 finished flags", {busy, done}, 2'b01);
        check(expq.size() == 0, "R8 read count", expq.size(), 0);
        check(!phase_bad && !stab_bad, "R4 MDC timing and data stability", {phase_bad, stab_bad}, 0);
        check(!coll_bad, "R8 line released on read", coll_bad, 0);
        check(!en_bad && mgmt_en, "R2 enable before MDC", {en_bad, mgmt_en}, 1);
        expq.delete();
    endtask

    initial begin : driver
        repeat (4) @(negedge clk);
        check(!busy && !done && !link_up && !timeout, "R1 status at reset",
              {busy, done, link_up, timeout}, 0);
        check(!mgmt_en && !mdc && !mdio_oe && mdio_o, "R1 line at reset",
              {mgmt_en, mdc, mdio_oe, mdio_o}, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!mgmt_en && !mdc && !busy, "R1 idle after reset", {mgmt_en, mdc, busy}, 0);
        // link on first poll, with an ignored start during the quiet wait
        run_case(1, 1, 1'b1, 1'b1, "first poll");
        // link arrives on the read that also passes the budget: link wins
        run_case(3, 3, 1'b1, 1'b0, "same-cycle link and budget");
        // never links: timeout after third read
        run_case(0, 3, 1'b0, 1'b0, "no link");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule